// File: doc/BRIEF.md
# Clocked Serial Transmit Controller

This block sends 8-bit words one bit at a time on a serial data line. Each bit lines up with a serial clock. A small eight-entry buffer holds the words to send, and a word-count field picks how many of its entries go out. The lowest entry goes first, and the words follow one another with no gap. The serial clock can come from one of two sources. The block can make it from the system clock and drive it out, or it can take it from an input pin. An external clock passes through a synchronizer before edge detection.

Software controls the block through a few write strobes. Writing the start bit while the block is idle begins a transfer. Clearing the start bit during a transfer lets the current word finish and then stops the block. Setting the inhibit bit stops the block at once, even in the middle of a word. In external-clock mode, the start bit may still be set when the buffered words run out and the far end keeps clocking. In that case one extra all-ones word goes out before the transfer ends.

Each finished word raises a one-cycle interrupt and sets a sticky shift-end flag. A busy output tells software when the whole transfer is over.

Top module: `sertx_ctrl`

## Requirements
- R1: Each word is 8 bits, sent least significant bit first (bit 0 up to bit 7). A new bit appears on `so_out` in the same cycle that `sck_out` falls.
- R2: With the internal clock, `sck_out` idles high. Each serial period is 2*HALF_DIV system cycles: low for the first half and high for the second. A word takes exactly 8 periods, and consecutive words follow with no extra cycles.
- R3: `ctl_words` holds the word count minus one (0 means 1 word, 7 means 8 words). A transfer sends buffer entries 0, 1, ... up to that count, in that order.
- R4: `busy` goes to 1 on the clock edge that takes a start write (`ctl_we`=1, `ctl_start`=1, `ctl_inhibit`=0) while idle. It goes to 0 on the edge that completes the last word, which is the same cycle as that word's `irq`.
- R5: A control write with `ctl_start`=0 during a transfer lets the current word finish all 8 bits. No further word is sent after it.
- R6: A control write with `ctl_inhibit`=1 sets `busy` to 0 on the next edge. It also returns `sck_out` and `so_out` high, and no `irq` follows.
- R7: With the external clock (`ctl_ext`=1), `sck_in` passes through a two-flop synchronizer and an edge register. A falling edge drives the next bit on `so_out` 3 system cycles after the pin changes. The rising edge that follows completes that bit.
- R8: With the external clock, the start bit may still be set when the last buffered word completes. The block then sends one word of 0xFF on further clock edges and ends after it.
- R9: A control write while `busy`=1 leaves the clock source and word count unchanged. Only its start and inhibit bits take effect.
- R10: Each completed word gives a one-cycle `irq` pulse, and `shift_end` is set in the same cycle.
- R11: `shift_end` stays set until an `end_clr` strobe or until a new transfer starts. A word completing in the same cycle as `end_clr` leaves the flag set.
- R12: After reset, `busy`=0, `sck_out`=1, `so_out`=1, `shift_end`=0 and `irq`=0. While idle, `sck_out` and `so_out` stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_start | input | 1 | Start/continue bit of the control write |
| ctl_inhibit | input | 1 | Immediate-abort bit of the control write |
| ctl_ext | input | 1 | Clock source: 0 internal, 1 external (taken only when idle) |
| ctl_words | input | AW | Word count minus one (taken only when idle) |
| buf_we | input | 1 | Buffer write strobe |
| buf_addr | input | AW | Buffer entry to write |
| buf_wdata | input | 8 | Word to store |
| end_clr | input | 1 | Write-one-to-clear strobe for the shift-end flag |
| sck_in | input | 1 | External serial clock |
| sck_out | output | 1 | Generated serial clock, idles high |
| so_out | output | 1 | Serial data, idles high |
| busy | output | 1 | Transfer in progress |
| shift_end | output | 1 | Sticky word-complete flag |
| irq | output | 1 | One-cycle pulse per completed word |

## Verification
The bench targets several corner cases.

- **Stop bit cleared mid-word.** A design that checked the start bit at every bit would cut the word short. One that ignored it would send the rest of the buffer.
- **Inhibit mid-word.** A design that treated inhibit like the start bit would keep clocking to the end of the word.
- **Word-count and source writes while busy.** A design that accepted them would change the number of words or the clock source partway through.
- **External clocks running past the buffer.** These must produce exactly one all-ones word with the start bit held, and nothing once it is cleared. A wrong design sends stale buffer data, loops forever, or skips the extra word.
- **Back-to-back words.** A design that inserts a gap, or miscounts the boundary between words, shows up as a shifted bit stream.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int unsigned WORD_BITS = 8;

    typedef logic [WORD_BITS-1:0] word_t;

    localparam word_t FILL_WORD = '1;

    typedef enum logic {
        SRC_INT = 1'b0,
        SRC_EXT = 1'b1
    } clk_src_e;

    typedef struct packed {
        logic fall;
        logic rise;
    } edge_t;

    typedef enum logic [1:0] {
        NX_ADVANCE = 2'd0,
        NX_FILL    = 2'd1,
        NX_FINISH  = 2'd2
    } word_next_e;

    // Decide what follows a completed word.
    function automatic word_next_e pick_next(input logic keep_going,
                                             input logic more_left,
                                             input logic ext_src,
                                             input logic filled);
        word_next_e res;
        if (!keep_going)
            res = NX_FINISH;
        else if (more_left)
            res = NX_ADVANCE;
        else if (ext_src && !filled)
            res = NX_FILL;
        else
            res = NX_FINISH;
        return res;
    endfunction

endpackage

// File: rtl/sertx_clkgen.sv
module sertx_clkgen
    import sertx_pkg::*;
#(
    parameter int unsigned HALF_DIV    = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  clk_src_e src,
    input  logic     sck_in,
    output edge_t    tick
);

    localparam int unsigned PERIOD = 2 * HALF_DIV;
    localparam int unsigned CW     = (PERIOD > 2) ? $clog2(PERIOD) : 1;

    logic [CW-1:0]        div_q;
    logic [SYNC_STAGES:0] sync_q;
    logic                 ext_now;
    logic                 ext_prev;

    always_ff @(posedge clk) begin
        if (rst)
            div_q <= '0;
        else if (run && src == SRC_INT)
            div_q <= (div_q == CW'(PERIOD - 1)) ? '0 : div_q + 1'b1;
        else
            div_q <= '0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            sync_q <= '1;
        else
            sync_q <= {sync_q[SYNC_STAGES-1:0], sck_in};
    end

    assign ext_now  = sync_q[SYNC_STAGES-1];
    assign ext_prev = sync_q[SYNC_STAGES];

    always_comb begin
        tick = '0;
        if (run) begin
            if (src == SRC_INT) begin
                tick.fall = (div_q == '0);
                tick.rise = (div_q == CW'(HALF_DIV));
            end else begin
                tick.fall = ext_prev & ~ext_now;
                tick.rise = ~ext_prev & ext_now;
            end
        end
    end

endmodule

// File: rtl/sertx_buf.sv
module sertx_buf
    import sertx_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  word_t         wr_data,
    input  logic [AW-1:0] rd_addr,
    output word_t         rd_data
);

    word_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(DEPTH); i++)
                mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
#(
    parameter int unsigned AW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ctl_we,
    input  logic          ctl_start,
    input  logic          ctl_inhibit,
    input  logic          ctl_ext,
    input  logic [AW-1:0] ctl_words,
    input  logic          end_clr,
    input  edge_t         tick,
    input  word_t         rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          busy,
    output clk_src_e      src,
    output logic          sck_out,
    output logic          so_out,
    output logic          shift_end,
    output logic          irq
);

    localparam int unsigned BW = $clog2(WORD_BITS);

    logic          busy_q;
    logic          start_q;
    clk_src_e      src_q;
    logic [AW-1:0] words_q;
    logic [AW-1:0] idx_q;
    logic [BW-1:0] bit_q;
    logic          half_q;
    logic          fill_q;
    word_t         data_q;
    logic          sck_q;
    logic          so_q;
    logic          end_q;
    logic          irq_q;

    assign rd_addr = busy_q ? idx_q + 1'b1 : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            start_q <= 1'b0;
            src_q   <= SRC_INT;
            words_q <= '0;
            idx_q   <= '0;
            bit_q   <= '0;
            half_q  <= 1'b0;
            fill_q  <= 1'b0;
            data_q  <= '0;
            sck_q   <= 1'b1;
            so_q    <= 1'b1;
            end_q   <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (ctl_we && !busy_q) begin
                src_q   <= clk_src_e'(ctl_ext);
                words_q <= ctl_words;
            end
            if (end_clr)
                end_q <= 1'b0;

            if (ctl_we && ctl_inhibit) begin
                busy_q  <= 1'b0;
                start_q <= 1'b0;
                sck_q   <= 1'b1;
                so_q    <= 1'b1;
                half_q  <= 1'b0;
            end else if (ctl_we && ctl_start && !busy_q) begin
                busy_q  <= 1'b1;
                start_q <= 1'b1;
                end_q   <= 1'b0;
                idx_q   <= '0;
                bit_q   <= '0;
                half_q  <= 1'b0;
                fill_q  <= 1'b0;
                data_q  <= rd_data;
            end else begin
                if (ctl_we)
                    start_q <= ctl_start;
                if (busy_q && tick.fall) begin
                    so_q   <= data_q[bit_q];
                    half_q <= 1'b1;
                    if (src_q == SRC_INT)
                        sck_q <= 1'b0;
                end
                if (busy_q && tick.rise && half_q) begin
                    sck_q  <= 1'b1;
                    half_q <= 1'b0;
                    if (bit_q == BW'(WORD_BITS - 1)) begin
                        irq_q <= 1'b1;
                        end_q <= 1'b1;
                        bit_q <= '0;
                        case (pick_next(start_q, idx_q != words_q,
                                        src_q == SRC_EXT, fill_q))
                            NX_ADVANCE: begin
                                idx_q  <= idx_q + 1'b1;
                                data_q <= rd_data;
                            end
                            NX_FILL: begin
                                fill_q <= 1'b1;
                                data_q <= FILL_WORD;
                            end
                            default: begin
                                busy_q  <= 1'b0;
                                start_q <= 1'b0;
                                so_q    <= 1'b1;
                            end
                        endcase
                    end else begin
                        bit_q <= bit_q + 1'b1;
                    end
                end
            end
        end
    end

    assign busy      = busy_q;
    assign src       = src_q;
    assign sck_out   = sck_q;
    assign so_out    = so_q;
    assign shift_end = end_q;
    assign irq       = irq_q;

endmodule

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
    import sertx_pkg::*;
#(
    parameter int unsigned DEPTH       = 8,
    parameter int unsigned HALF_DIV    = 2,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned AW         = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ctl_we,
    input  logic          ctl_start,
    input  logic          ctl_inhibit,
    input  logic          ctl_ext,
    input  logic [AW-1:0] ctl_words,
    input  logic          buf_we,
    input  logic [AW-1:0] buf_addr,
    input  logic [7:0]    buf_wdata,
    input  logic          end_clr,
    input  logic          sck_in,
    output logic          sck_out,
    output logic          so_out,
    output logic          busy,
    output logic          shift_end,
    output logic          irq
);

    edge_t         tick;
    word_t         rd_data;
    logic [AW-1:0] rd_addr;
    clk_src_e      src;

    sertx_clkgen #(
        .HALF_DIV    (HALF_DIV),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_clkgen (
        .clk    (clk),
        .rst    (rst),
        .run    (busy),
        .src    (src),
        .sck_in (sck_in),
        .tick   (tick)
    );

    sertx_buf #(
        .DEPTH (DEPTH)
    ) u_buf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (buf_we),
        .wr_addr (buf_addr),
        .wr_data (buf_wdata),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    sertx_shifter #(
        .AW (AW)
    ) u_shift (
        .clk         (clk),
        .rst         (rst),
        .ctl_we      (ctl_we),
        .ctl_start   (ctl_start),
        .ctl_inhibit (ctl_inhibit),
        .ctl_ext     (ctl_ext),
        .ctl_words   (ctl_words),
        .end_clr     (end_clr),
        .tick        (tick),
        .rd_data     (rd_data),
        .rd_addr     (rd_addr),
        .busy        (busy),
        .src         (src),
        .sck_out     (sck_out),
        .so_out      (so_out),
        .shift_end   (shift_end),
        .irq         (irq)
    );

endmodule

// File: rtl/sertx_ctrl_chk.sv
module sertx_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic ctl_we,
    input logic ctl_inhibit,
    input logic sck_out,
    input logic so_out,
    input logic busy,
    input logic shift_end,
    input logic irq
);

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sck_out && so_out)); // R12

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq); // R10

    AST_IRQ_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq |-> shift_end); // R10

    AST_ABORT_NOW: assert property (@(posedge clk) disable iff (rst)
        (ctl_we && ctl_inhibit) |=> (!busy && !irq)); // R6

    AST_START_CLEARS_END: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !shift_end); // R11

    AST_END_WITH_IRQ: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !$past(ctl_we && ctl_inhibit)) |-> irq); // R4

endmodule

bind sertx_ctrl sertx_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ctl_we      (ctl_we),
    .ctl_inhibit (ctl_inhibit),
    .sck_out     (sck_out),
    .so_out      (so_out),
    .busy        (busy),
    .shift_end   (shift_end),
    .irq         (irq)
);

// File: tb/sertx_ctrl_tb.sv
`timescale 1ns/1ps
module sertx_ctrl_tb;

    localparam int HALF = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_we = 1'b0, ctl_start = 1'b0, ctl_inhibit = 1'b0, ctl_ext = 1'b0;
    logic [2:0] ctl_words = '0;
    logic       buf_we = 1'b0;
    logic [2:0] buf_addr = '0;
    logic [7:0] buf_wdata = '0;
    logic       end_clr = 1'b0;
    logic       sck_in = 1'b1;
    logic       sck_out, so_out, busy, shift_end, irq;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R12";
    bit    finished = 0;

    always #2.5 clk = ~clk;

    sertx_ctrl #(.DEPTH(8), .HALF_DIV(HALF), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_start(ctl_start),
        .ctl_inhibit(ctl_inhibit), .ctl_ext(ctl_ext), .ctl_words(ctl_words),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
        .end_clr(end_clr), .sck_in(sck_in), .sck_out(sck_out), .so_out(so_out),
        .busy(busy), .shift_end(shift_end), .irq(irq)
    );

    // Behavioural reference model
    logic [7:0] m_buf [8];
    logic [7:0] m_data;
    logic m_busy, m_start, m_ext, m_half, m_dummy, m_sck, m_so, m_end, m_irq;
    logic m_s0, m_s1, m_prev, f_ev, r_ev, was_busy, was_start;
    int   m_words, m_word, m_bit, m_div;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 8; i++) m_buf[i] = 8'h00;
            m_data = 8'h00; m_busy = 0; m_start = 0; m_ext = 0; m_half = 0;
            m_dummy = 0; m_sck = 1; m_so = 1; m_end = 0; m_irq = 0;
            m_s0 = 1; m_s1 = 1; m_prev = 1; m_words = 0; m_word = 0; m_bit = 0; m_div = 0;
        end else begin
            f_ev = 0; r_ev = 0;
            if (m_busy) begin
                if (m_ext) begin
                    f_ev = m_prev && !m_s1;
                    r_ev = !m_prev && m_s1;
                end else begin
                    f_ev = (m_div == 0);
                    r_ev = (m_div == HALF);
                end
            end
            m_prev = m_s1; m_s1 = m_s0; m_s0 = sck_in;
            m_div = (m_busy && !m_ext) ? (m_div + 1) % (2 * HALF) : 0;
            was_busy = m_busy; was_start = m_start;
            m_irq = 0;
            if (end_clr) m_end = 0;
            if (ctl_we && ctl_inhibit) begin
                m_busy = 0; m_start = 0; m_sck = 1; m_so = 1; m_half = 0;
            end else if (ctl_we && ctl_start && !was_busy) begin
                m_busy = 1; m_start = 1; m_end = 0; m_word = 0; m_bit = 0;
                m_half = 0; m_dummy = 0; m_data = m_buf[0];
            end else begin
                if (ctl_we) m_start = ctl_start;
                if (was_busy && f_ev) begin
                    m_so = m_data[m_bit]; m_half = 1;
                    if (!m_ext) m_sck = 0;
                end else if (was_busy && r_ev && m_half) begin
                    m_sck = 1; m_half = 0;
                    if (m_bit == 7) begin
                        m_irq = 1; m_end = 1; m_bit = 0;
                        if (was_start && m_word < m_words) begin
                            m_word++; m_data = m_buf[m_word];
                        end else if (was_start && m_ext && !m_dummy) begin
                            m_dummy = 1; m_data = 8'hFF;
                        end else begin
                            m_busy = 0; m_start = 0; m_so = 1;
                        end
                    end else begin
                        m_bit++;
                    end
                end
            end
            if (ctl_we && !was_busy) begin
                m_ext = ctl_ext; m_words = int'(ctl_words);
            end
            if (buf_we) m_buf[buf_addr] = buf_wdata;
        end
    end

    task automatic cmp(input string name, input logic got, input logic exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b at %0t", cur_req, name, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !finished) begin
            cmp("busy", busy, m_busy);
            cmp("sck_out", sck_out, m_sck);
            cmp("so_out", so_out, m_so);
            cmp("shift_end", shift_end, m_end);
            cmp("irq", irq, m_irq);
        end
    end

    task automatic write_ctl(input logic st, input logic inh, input logic ext, input logic [2:0] w);
        @(negedge clk);
        ctl_we = 1; ctl_start = st; ctl_inhibit = inh; ctl_ext = ext; ctl_words = w;
        @(negedge clk);
        ctl_we = 0; ctl_start = 0; ctl_inhibit = 0;
    endtask

    task automatic write_buf(input int a, input logic [7:0] d);
        @(negedge clk);
        buf_we = 1; buf_addr = 3'(a); buf_wdata = d;
        @(negedge clk);
        buf_we = 0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); end_clr = 1;
        @(negedge clk); end_clr = 0;
    endtask

    task automatic ext_clocks(input int n);
        for (int k = 0; k < n; k++) begin
            sck_in = 0; repeat (4) @(negedge clk);
            sck_in = 1; repeat (4) @(negedge clk);
        end
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 3000 && busy; k++) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        cur_req = "R12";
        repeat (4) @(negedge clk);
        for (int i = 0; i < 8; i++) write_buf(i, 8'(8'h3C + i * 8'h29));

        cur_req = "R1";  write_ctl(1, 0, 0, 3'd0); wait_idle();
        cur_req = "R3";  write_ctl(1, 0, 0, 3'd2); wait_idle();
        cur_req = "R2";  write_ctl(1, 0, 0, 3'd7); wait_idle();
        cur_req = "R11"; pulse_clr(); repeat (3) @(negedge clk);
        write_ctl(1, 0, 0, 3'd0); wait_idle();
        cur_req = "R4";  write_ctl(1, 0, 0, 3'd1); wait_idle();
        cur_req = "R5";  write_ctl(1, 0, 0, 3'd3);
        repeat (40) @(negedge clk);
        write_ctl(0, 0, 0, 3'd3); wait_idle();
        cur_req = "R9";  write_ctl(1, 0, 0, 3'd1);
        repeat (10) @(negedge clk);
        write_ctl(1, 0, 1, 3'd7); wait_idle();
        cur_req = "R6";  write_ctl(1, 0, 0, 3'd2);
        repeat (20) @(negedge clk);
        write_ctl(0, 1, 0, 3'd2); repeat (30) @(negedge clk);
        cur_req = "R10"; write_ctl(1, 0, 0, 3'd1);
        repeat (31) @(negedge clk);
        pulse_clr(); wait_idle();
        cur_req = "R7";  write_ctl(1, 0, 1, 3'd1);
        ext_clocks(12);
        write_ctl(0, 0, 1, 3'd1);
        ext_clocks(8); ext_clocks(4); repeat (8) @(negedge clk);
        cur_req = "R8";  write_ctl(1, 0, 1, 3'd1);
        ext_clocks(26); repeat (8) @(negedge clk);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL %s watchdog: actual running expected done", cur_req);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule